// File: doc/BRIEF.md
# Ring-Oscillator Race Response Generator

This block turns an 8-bit challenge into a 4-bit response by racing oscillators against each other. It has four banks, one for each response bit. Each bank takes sixteen free-running oscillator inputs. Both nibbles of the challenge are used as selectors by every bank. The high nibble picks the oscillator that drives the "first" edge counter. The low nibble picks the oscillator that drives the "second" edge counter. Whichever counter reaches the terminal count first decides the bit.

The oscillators come from outside the block as toggling signals. Each one passes through a two-flop synchroniser and a rising-edge detector in the system clock domain, so every part of the block is synchronous. A one-cycle start request clears all counters, latches the selectors and launches the four races. When every bank has finished, a single-cycle done flag rises. The response then holds until the next accepted start.

Top module: `ro_race_puf`

## Requirements
- R1: After reset, `response` is 0 and `done` is 0.
- R2: Bank b compares two oscillators: input `osc_in[b*16 + challenge[7:4]]` for the first counter and `osc_in[b*16 + challenge[3:0]]` for the second. Response bit b is 1 when the first counter reaches TERM synchronised rising edges strictly before the second counter does, and 0 when the second counter gets there first.
- R3: When both counters of a bank reach TERM in the same cycle, that response bit is 0. This always happens when the two challenge nibbles are equal.
- R4: The four banks race independently, and all of them use the same latched selectors. Both counters of every bank clear to zero on each accepted start.
- R5: `done` is high for exactly one cycle, once all four banks have finished, and it never stays high for two cycles in a row.
- R6: Between `done` and the next accepted start, `response` does not change.
- R7: A `start` that arrives while a race is running has no effect on that race or on its result.
- R8: The challenge is captured when a start is accepted. Changes on `challenge` during the race have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request; honoured only while idle |
| challenge | input | 8 | High nibble selects the first oscillator, low nibble the second |
| osc_in | input | 64 | Oscillator inputs, 16 per bank; bank b uses bits b*16 to b*16+15 |
| response | output | 4 | One race result per bank |
| done | output | 1 | One-cycle flag marking the end of all four races |

## Verification
The bench builds the block with TERM = 7, which keeps each race short enough for the bench to apply all 256 challenges. Every oscillator has a distinct half-period in clock cycles within its bank, and every oscillator starts low when a race begins. The expected winner is therefore the oscillator with the shorter half-period, and the bench computes it arithmetically for all four banks. The sweep covers every pair of selectors, including the sixteen equal-nibble ties. Some races also receive a stray start and a changing challenge while they run, to show that neither affects the result.

// File: rtl/ro_race_puf.sv
module ro_race_puf #(
  parameter int NBANK = 4,
  parameter int NOSC  = 16,
  parameter int TERM  = 255
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [2*$clog2(NOSC)-1:0] challenge,
  input  logic [NBANK*NOSC-1:0]    osc_in,
  output logic [NBANK-1:0]         response,
  output logic                     done
);
  localparam int SELW = $clog2(NOSC);
  localparam int CW   = $clog2(TERM + 1);
  localparam logic [CW-1:0] LAST = CW'(TERM - 1);

  logic [NBANK*NOSC-1:0] s1, s2, s3;
  logic [NBANK*NOSC-1:0] rise;
  logic                  busy;
  logic [SELW-1:0]       sel_a, sel_b;
  logic [NBANK-1:0]      fin;
  logic                  go;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= osc_in;
      s2 <= s1;
      s3 <= s2;
    end

  assign rise = s2 & ~s3;
  assign go   = start & ~busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      sel_a <= '0;
      sel_b <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy  <= 1'b1;
        sel_a <= challenge[2*SELW-1:SELW];
        sel_b <= challenge[SELW-1:0];
      end else if (busy && (&fin)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [NOSC-1:0] bank_rise;
    logic [CW-1:0]   cnt_a, cnt_b;
    logic            ea, eb, hit_a, hit_b, live;

    assign bank_rise = rise[b*NOSC +: NOSC];
    assign ea    = bank_rise[sel_a];
    assign eb    = bank_rise[sel_b];
    assign live  = busy & ~fin[b];
    assign hit_a = live & ea & (cnt_a == LAST);
    assign hit_b = live & eb & (cnt_b == LAST);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt_a       <= '0;
        cnt_b       <= '0;
        fin[b]      <= 1'b0;
        response[b] <= 1'b0;
      end else if (go) begin
        cnt_a       <= '0;
        cnt_b       <= '0;
        fin[b]      <= 1'b0;
        response[b] <= 1'b0;
      end else if (live) begin
        cnt_a <= cnt_a + CW'(ea);
        cnt_b <= cnt_b + CW'(eb);
        if (hit_a || hit_b) begin
          fin[b]      <= 1'b1;
          response[b] <= hit_a & ~hit_b;
        end
      end
  end
endmodule

module ro_race_puf_chk #(
  parameter int NBANK = 4,
  parameter int SELW  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic [NBANK-1:0] fin,
  input logic [SELW-1:0]  sel_a,
  input logic [SELW-1:0]  sel_b,
  input logic [NBANK-1:0] response,
  input logic             done
);
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_done_all_fin: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(&fin) && !busy));

  a_r6_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(response));

  a_r8_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(sel_a) && $stable(sel_b)));

  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(&fin)) |=> busy);

  a_r3_tie_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (sel_a == sel_b)) |-> (response == '0));
endmodule

bind ro_race_puf ro_race_puf_chk #(.NBANK(NBANK), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .fin(fin),
  .sel_a(sel_a), .sel_b(sel_b), .response(response), .done(done)
);

// File: tb/ro_race_puf_tb.sv
`timescale 1ns/1ps
module ro_race_puf_tb;
  localparam int NBANK = 4;
  localparam int NOSC  = 16;
  localparam int TERM  = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  challenge = '0;
  logic [63:0] osc_in;
  logic [3:0]  response;
  logic        done;

  int  vecs = 0;
  int  errs = 0;
  int  t = 0;
  bit  run = 1'b0;

  always #4 clk = ~clk;

  ro_race_puf #(.NBANK(NBANK), .NOSC(NOSC), .TERM(TERM)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .challenge(challenge),
    .osc_in(osc_in), .response(response), .done(done)
  );

  function automatic int half_per(int b, int i);
    return 1 + ((i * 7 + b * 5) % 16);
  endfunction

  always_comb
    for (int b = 0; b < NBANK; b++)
      for (int i = 0; i < NOSC; i++)
        osc_in[b*NOSC + i] = run ? (((t / half_per(b, i)) % 2) == 1) : 1'b0;

  always @(negedge clk) if (run) t <= t + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expect_resp(logic [7:0] c);
    logic [3:0] r;
    for (int b = 0; b < NBANK; b++)
      r[b] = half_per(b, c[7:4]) < half_per(b, c[3:0]);
    return r;
  endfunction

  initial begin
    #(8 * 190000);
    errs++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(response == 4'h0, "R1 response", response, 0);
    check(done == 1'b0, "R1 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(response == 4'h0 && done == 1'b0, "R1 after release", {done, response}, 0);

    for (int c = 0; c < 256; c++) begin
      logic [3:0] exp_r;
      logic [3:0] held;
      int wait_n;
      exp_r = expect_resp(8'(c));
      run = 1'b0;
      t = 0;
      repeat (4) @(negedge clk);
      challenge = 8'(c);
      start = 1'b1;
      run = 1'b1;
      @(negedge clk);
      start = 1'b0;
      challenge = ~8'(c);
      wait_n = 1;
      while (!done && wait_n < 3000) begin
        if (wait_n == 6 && (c % 5) == 2) begin
          start = 1'b1;
          challenge = 8'(c) ^ 8'h5A;
        end else begin
          start = 1'b0;
          challenge = 8'(c + wait_n);
        end
        @(negedge clk);
        wait_n++;
      end
      start = 1'b0;
      check(done == 1'b1, "R5 done seen", done, 1);
      if ((c >> 4) == (c & 15))
        check(response == 4'h0, "R3 tie gives zero", response, 0);
      else if ((c % 5) == 2)
        check(response == exp_r, "R7/R8 race result", response, exp_r);
      else
        check(response == exp_r, "R2/R4 race result", response, exp_r);
      held = response;
      @(negedge clk);
      check(done == 1'b0, "R5 one-cycle done", done, 0);
      run = 1'b0;
      repeat (8) @(negedge clk);
      check(response == held, "R6 response held", response, held);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule